// File: doc/BRIEF.md
# Display FIFO Refill Timing Calculator

This block computes the two control words that set how a display FIFO is refilled from video memory. From the memory and pixel clock divider settings, the pixel depth, the FIFO depth and the memory delays, it derives three values. The first is a fixed-point precision. The second is a pair of turn-on and turn-off thresholds for refill requests. The third is the number of memory clocks per FIFO entry. The block packs these values into an on/off word and a configuration word.

The caller places the operands on the inputs and pulses `start`. The block captures the operands and holds `busy` while it works. First it removes common factors of two from the clock ratio. It then runs five long divisions, one after another, on a shared serial divider. It finishes with rounding and packing. A one-cycle `done` pulse marks valid results. If the divisor is zero, `err` is raised with `done` and the previous words are kept.

Top module: `dsp_timing_calc`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and both output words are 0.
- R2: The ratio numerator M is mem_fb_div × pix_post_val. The ratio denominator D is pix_fb_div × mem_ref_div. D is further multiplied by pix_bpp>>2 when pix_bpp ≥ 8. A base shift vb = 4 − mem_post_code is used, lowered by one more when pix_bpp is 0.
- R3: Before any division, M and D are both halved for as long as both are even. Every later result uses the reduced values.
- R4: The fill value is F = ((M × fifo_depth) << vb) / D. The precision p is (bit length of F) − 5, clamped to 0..7. The shift xs is 6 − p, floored at 0. The full shift is vs = vb + xs. p appears in config_word bits 22:20.
- R5: off = ((M × (fifo_depth − 1)) << vs) / D − (1 << vb), taken modulo 2^32 (fifo_depth ≥ 1).
- R6: on starts as ((M << vs) + D) / D. With t = (ras_delay << xs) + 1, on is raised to t if it is smaller. Then 2t + (pf_delay << xs) is added.
- R7: on is rounded up to a multiple of g = 1 << xs. If the rounded on is ≥ off rounded down to a multiple of g, on is replaced. The new value is (off − ((M << vs) / D)) modulo 2^32, rounded down to a multiple of g.
- R8: on_off_word = ((on << 16) + off) mod 2^32. config_word = (p << 20) | (loop_lat << 16) | xclk, where xclk = ((M << (vs + 5)) + D) / D.
- R9: If D is zero (before reduction), `done` and `err` rise together within two cycles of `start`. Both output words keep their previous values.
- R10: Operands are captured at `start`. A `start` while `busy` is ignored. `done` is a single-cycle pulse, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation with the present operands |
| mem_fb_div | input | 8 | Memory clock feedback divider |
| pix_post_val | input | 4 | Pixel clock post-divide value |
| pix_fb_div | input | 8 | Pixel clock feedback divider |
| mem_ref_div | input | 2 | Memory clock reference divider |
| mem_post_code | input | 2 | Memory clock post-divider code |
| pix_bpp | input | 6 | Bits per pixel, 0 for the 32-bit FIFO mode |
| fifo_depth | input | 6 | FIFO depth in entries, at least 1 |
| ras_delay | input | 4 | Row-activate delay in memory clocks |
| pf_delay | input | 4 | Page-fault delay in memory clocks |
| loop_lat | input | 4 | Refill loop latency field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Zero denominator on the last request |
| on_off_word | output | 32 | Packed on/off thresholds |
| config_word | output | 32 | Packed precision, latency and clocks-per-entry |

## Verification
Several corner cases are targeted. One is the precision clamp at both ends: a fast memory clock against a slow pixel clock at depth 63, and the reverse at depth 1. A design that skips the clamp or the xs floor produces wrong shifts in every field. Another is a ratio made of high powers of two, which catches a reduction that stops early or overshoots. Others are a zero pixel divider after a good run, which must not disturb the held words, and a second start issued mid-run with different operands, which a design that recaptures operands would corrupt. Random operands over all pixel depths reach the fallback branch of the on threshold, where a wrong rounding granule or a wrong subtraction shows up in the upper half of the on/off word.

// File: rtl/dsp_calc_pkg.sv
package dsp_calc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REDUCE = 2'd1,
    ST_DIVIDE = 2'd2,
    ST_PACK   = 2'd3
  } calc_state_t;

  localparam int unsigned NUM_DIVS = 5;

  // Precision from the bit length of the fill value, clamped to 0..7.
  function automatic logic [2:0] prec_from_fill(input logic [63:0] v);
    int blen;
    blen = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) blen = i + 1;
    end
    blen = blen - 5;
    if (blen < 0) blen = 0;
    if (blen > 7) blen = 7;
    return 3'(blen);
  endfunction

  // Fraction shift 6 - p, floored at zero; also the rounding granule exponent.
  function automatic logic [3:0] frac_shift(input logic [2:0] p);
    return (p == 3'd7) ? 4'd0 : (4'd6 - {1'b0, p});
  endfunction

endpackage

// File: rtl/dsp_sdiv.sv
module dsp_sdiv #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] q_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, q_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        q_q   <= num;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;
endmodule

// File: rtl/dsp_finalize.sv
module dsp_finalize #(
  parameter int NUM_W = 32,
  parameter int DLYW  = 4,
  parameter int LATW  = 4
) (
  input  logic [NUM_W-1:0] q_off,
  input  logic [NUM_W-1:0] q_on,
  input  logic [NUM_W-1:0] q_step,
  input  logic [NUM_W-1:0] q_xclk,
  input  logic [2:0]       prec,
  input  logic [2:0]       vb,
  input  logic [3:0]       xs,
  input  logic [DLYW-1:0]  ras,
  input  logic [DLYW-1:0]  pf,
  input  logic [LATW-1:0]  lat,
  output logic [31:0]      onoff,
  output logic [31:0]      cfg
);
  logic [31:0] t, on_a, on_b, on_c, on_d, off, gmask;

  always_comb begin
    gmask = ~((32'd1 << xs) - 32'd1);
    t     = (32'(ras) << xs) + 32'd1;
    off   = 32'(q_off) - (32'd1 << vb);
    on_a  = 32'(q_on);
    on_b  = (on_a < t) ? t : on_a;
    on_c  = on_b + (t << 1) + (32'(pf) << xs);
    on_c  = (on_c + ~gmask) & gmask;
    if (on_c >= (off & gmask))
      on_d = (off - 32'(q_step)) & gmask;
    else
      on_d = on_c;
    onoff = (on_d << 16) + off;
    cfg   = (32'(prec) << 20) | (32'(lat) << 16) | 32'(q_xclk);
  end
endmodule

// File: rtl/dsp_timing_calc.sv
module dsp_timing_calc
  import dsp_calc_pkg::*;
#(
  parameter int FBW  = 8,
  parameter int PDW  = 4,
  parameter int REFW = 2,
  parameter int BPPW = 6,
  parameter int DEPW = 6,
  parameter int DLYW = 4,
  parameter int LATW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FBW-1:0]  mem_fb_div,
  input  logic [PDW-1:0]  pix_post_val,
  input  logic [FBW-1:0]  pix_fb_div,
  input  logic [REFW-1:0] mem_ref_div,
  input  logic [1:0]      mem_post_code,
  input  logic [BPPW-1:0] pix_bpp,
  input  logic [DEPW-1:0] fifo_depth,
  input  logic [DLYW-1:0] ras_delay,
  input  logic [DLYW-1:0] pf_delay,
  input  logic [LATW-1:0] loop_lat,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [31:0]     on_off_word,
  output logic [31:0]     config_word
);
  localparam int MUL_W = FBW + PDW;
  localparam int DEN_W = FBW + REFW + BPPW - 2;
  localparam int NUM_W = MUL_W + DEPW + 14;

  calc_state_t     st_q;
  logic [MUL_W-1:0] mul_q, mul_in;
  logic [DEN_W-1:0] dv_q, dv_in, dv_base;
  logic [2:0]       vb_q, vb_in;
  logic [DEPW-1:0]  dep_q;
  logic [DLYW-1:0]  ras_q, pf_q;
  logic [LATW-1:0]  lat_q;
  logic [2:0]       k_q;
  logic             issued_q, done_q, err_q;
  logic [31:0]      onoff_q, cfg_q;
  logic [NUM_W-1:0] qv [NUM_DIVS];

  logic             div_go, div_done;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [2:0]       prec_w;
  logic [3:0]       xs_w, vs_w;
  logic [31:0]      fin_onoff, fin_cfg;

  // named internal events for the checker
  logic             first_div_launch, red_mul_odd, red_dv_odd;

  always_comb begin
    mul_in  = MUL_W'(mem_fb_div) * MUL_W'(pix_post_val);
    dv_base = DEN_W'(pix_fb_div) * DEN_W'(mem_ref_div);
    dv_in   = (pix_bpp >= BPPW'(8)) ? dv_base * DEN_W'(pix_bpp >> 2) : dv_base;
    vb_in   = 3'd4 - {1'b0, mem_post_code} - {2'b0, (pix_bpp == '0)};
  end

  assign prec_w = prec_from_fill(64'(qv[0]));
  assign xs_w   = frac_shift(prec_w);
  assign vs_w   = {1'b0, vb_q} + xs_w;

  always_comb begin
    case (k_q)
      3'd0:    div_num = (NUM_W'(mul_q) * NUM_W'(dep_q)) << vb_q;
      3'd1:    div_num = (NUM_W'(mul_q) * NUM_W'(dep_q - DEPW'(1))) << vs_w;
      3'd2:    div_num = (NUM_W'(mul_q) << vs_w) + NUM_W'(dv_q);
      3'd3:    div_num = NUM_W'(mul_q) << vs_w;
      default: div_num = (NUM_W'(mul_q) << (vs_w + 4'd5)) + NUM_W'(dv_q);
    endcase
  end

  assign div_go           = (st_q == ST_DIVIDE) && !issued_q;
  assign first_div_launch = div_go && (k_q == 3'd0);
  assign red_mul_odd      = mul_q[0];
  assign red_dv_odd       = dv_q[0];

  dsp_sdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(dv_q),
    .done(div_done), .quo(div_quo)
  );

  dsp_finalize #(.NUM_W(NUM_W), .DLYW(DLYW), .LATW(LATW)) u_fin (
    .q_off(qv[1]), .q_on(qv[2]), .q_step(qv[3]), .q_xclk(qv[4]),
    .prec(prec_w), .vb(vb_q), .xs(xs_w), .ras(ras_q), .pf(pf_q), .lat(lat_q),
    .onoff(fin_onoff), .cfg(fin_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mul_q    <= '0;
      dv_q     <= '0;
      vb_q     <= '0;
      dep_q    <= '0;
      ras_q    <= '0;
      pf_q     <= '0;
      lat_q    <= '0;
      k_q      <= '0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      onoff_q  <= '0;
      cfg_q    <= '0;
      for (int i = 0; i < NUM_DIVS; i++) qv[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          mul_q <= mul_in;
          dv_q  <= dv_in;
          vb_q  <= vb_in;
          dep_q <= fifo_depth;
          ras_q <= ras_delay;
          pf_q  <= pf_delay;
          lat_q <= loop_lat;
          if (dv_in == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            err_q <= 1'b0;
            st_q  <= ST_REDUCE;
          end
        end
        ST_REDUCE: begin
          if (!mul_q[0] && !dv_q[0]) begin
            mul_q <= mul_q >> 1;
            dv_q  <= dv_q >> 1;
          end else begin
            st_q     <= ST_DIVIDE;
            k_q      <= '0;
            issued_q <= 1'b0;
          end
        end
        ST_DIVIDE: begin
          if (div_go) issued_q <= 1'b1;
          if (div_done) begin
            qv[k_q]  <= div_quo;
            issued_q <= 1'b0;
            if (k_q == 3'(NUM_DIVS - 1)) st_q <= ST_PACK;
            else k_q <= k_q + 3'd1;
          end
        end
        default: begin
          onoff_q <= fin_onoff;
          cfg_q   <= fin_cfg;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign on_off_word = onoff_q;
  assign config_word = cfg_q;
endmodule

// File: rtl/dsp_timing_calc_chk.sv
module dsp_timing_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [31:0] on_off_word,
  input logic [31:0] config_word,
  input logic        first_div_launch,
  input logic        red_mul_odd,
  input logic        red_dv_odd
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r9_words_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(on_off_word) && $stable(config_word)));

  a_r3_reduced_before_divide: assert property (@(posedge clk) disable iff (!rst_n)
    first_div_launch |-> (red_mul_odd || red_dv_odd));
endmodule

bind dsp_timing_calc dsp_timing_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .on_off_word(on_off_word), .config_word(config_word),
  .first_div_launch(first_div_launch), .red_mul_odd(red_mul_odd),
  .red_dv_odd(red_dv_odd)
);

// File: tb/dsp_timing_calc_test.sv
module dsp_timing_calc_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] mem_fb_div = '0, pix_fb_div = '0;
  logic [3:0] pix_post_val = '0, ras_delay = '0, pf_delay = '0, loop_lat = '0;
  logic [1:0] mem_ref_div = '0, mem_post_code = '0;
  logic [5:0] pix_bpp = '0, fifo_depth = '0;
  logic busy, done, err;
  logic [31:0] on_off_word, config_word;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_timing_calc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_fb_div(mem_fb_div),
    .pix_post_val(pix_post_val), .pix_fb_div(pix_fb_div), .mem_ref_div(mem_ref_div),
    .mem_post_code(mem_post_code), .pix_bpp(pix_bpp), .fifo_depth(fifo_depth),
    .ras_delay(ras_delay), .pf_delay(pf_delay), .loop_lat(loop_lat),
    .busy(busy), .done(done), .err(err), .on_off_word(on_off_word),
    .config_word(config_word)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input int fb, post, pfb, rf, code, bpp, dep, ras, pf, lat,
                                output logic [31:0] eo, output logic [31:0] ec, output bit ee);
    longint m, d, f, off, on, t, r, stp, xc;
    longint mask32 = 64'h0000_0000_FFFF_FFFF;
    int p, vb, xs, vs;
    eo = '0; ec = '0;
    m = fb * post;
    d = pfb * rf;
    if (bpp >= 8) d = d * (bpp / 4);
    if (d == 0) begin ee = 1; return; end
    ee = 0;
    while ((m % 2 == 0) && (d % 2 == 0)) begin m = m / 2; d = d / 2; end
    vb = 4 - code - ((bpp == 0) ? 1 : 0);
    f = (m * dep * (longint'(1) << vb)) / d;
    p = -5;
    while (f != 0) begin f = f / 2; p++; end
    if (p < 0) p = 0;
    if (p > 7) p = 7;
    xs = (p > 6) ? 0 : 6 - p;
    vs = vb + xs;
    off = ((m * (dep - 1) * (longint'(1) << vs)) / d - (longint'(1) << vb)) & mask32;
    on = (m * (longint'(1) << vs) + d) / d;
    t = ras * (longint'(1) << xs) + 1;
    if (on < t) on = t;
    on = on + 2 * t + pf * (longint'(1) << xs);
    r = ((longint'(1) << (7 - p)) - 1) / 2;
    on = ((on + r) / (r + 1)) * (r + 1);
    if (on >= (off / (r + 1)) * (r + 1)) begin
      stp = (m * (longint'(1) << vs)) / d;
      on = (((off - stp) & mask32) / (r + 1)) * (r + 1);
    end
    xc = (m * (longint'(1) << (vs + 5)) + d) / d;
    eo = 32'((on * 65536 + off) & mask32);
    ec = 32'(longint'(p) * 1048576 | longint'(lat) * 65536 | xc);
  endfunction

  task automatic drive(input int fb, post, pfb, rf, code, bpp, dep, ras, pf, lat);
    mem_fb_div = 8'(fb); pix_post_val = 4'(post); pix_fb_div = 8'(pfb);
    mem_ref_div = 2'(rf); mem_post_code = 2'(code); pix_bpp = 6'(bpp);
    fifo_depth = 6'(dep); ras_delay = 4'(ras); pf_delay = 4'(pf); loop_lat = 4'(lat);
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    ok = done;
    if (!ok) check(0, "R10 watchdog on done", 0, 1);
  endtask

  task automatic run_case(input int fb, post, pfb, rf, code, bpp, dep, ras, pf, lat,
                          input string tag);
    logic [31:0] eo, ec, prev_o, prev_c;
    bit ee, ok;
    model(fb, post, pfb, rf, code, bpp, dep, ras, pf, lat, eo, ec, ee);
    prev_o = on_off_word; prev_c = config_word;
    @(negedge clk);
    drive(fb, post, pfb, rf, code, bpp, dep, ras, pf, lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (!ok) return;
    check(err == ee, {tag, " R9 err flag"}, err, ee);
    if (ee) begin
      check(on_off_word == prev_o, {tag, " R9 on_off held"}, on_off_word, prev_o);
      check(config_word == prev_c, {tag, " R9 config held"}, config_word, prev_c);
    end else begin
      check(on_off_word == eo, {tag, " R2 R3 R5 R6 R7 on_off"}, on_off_word, eo);
      check(config_word == ec, {tag, " R4 R8 config"}, config_word, ec);
    end
    @(negedge clk);
    check(!done, {tag, " R10 done single pulse"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int posts [8] = '{1, 2, 4, 8, 3, 5, 6, 12};
    int bpps [6] = '{0, 4, 8, 16, 24, 32};
    logic [31:0] eo, ec;
    bit ee, ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
    check(on_off_word == 0 && config_word == 0, "R1 reset words", on_off_word, 0);
    rst_n = 1'b1;

    // directed corners
    run_case(255, 12, 1, 1, 0, 0, 63, 15, 15, 9, "R4 clamp high");
    run_case(1, 1, 255, 3, 3, 32, 1, 0, 0, 3, "R4 clamp low");
    run_case(128, 8, 64, 2, 1, 16, 24, 4, 5, 8, "R3 powers of two");
    run_case(0, 4, 200, 1, 2, 8, 32, 6, 3, 10, "R2 zero numerator");
    run_case(150, 2, 180, 1, 2, 4, 32, 7, 6, 11, "R2 bpp below 8 unscaled");
    run_case(170, 3, 0, 1, 1, 16, 32, 5, 5, 2, "R9 zero pixel divider");
    run_case(170, 3, 90, 0, 1, 16, 32, 5, 5, 2, "R9 zero ref divider");

    // R10: second start during busy with other operands is ignored
    model(200, 4, 160, 1, 1, 16, 24, 6, 4, 7, eo, ec, ee);
    @(negedge clk);
    drive(200, 4, 160, 1, 1, 16, 24, 6, 4, 7);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R10 busy after start", busy, 1);
    repeat (20) @(negedge clk);
    drive(33, 5, 77, 3, 3, 0, 9, 1, 1, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      check(on_off_word == eo, "R10 start ignored on_off", on_off_word, eo);
      check(config_word == ec, "R10 start ignored config", config_word, ec);
      check(!busy, "R10 busy low at done", busy, 0);
    end
    repeat (4) @(negedge clk);
    check(!busy && !done, "R10 stays idle", {busy, done}, 0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      run_case(int'($urandom_range(255, 0)), posts[$urandom_range(7, 0)],
               int'($urandom_range(255, 1)), int'($urandom_range(3, 1)),
               int'($urandom_range(3, 0)), bpps[$urandom_range(5, 0)],
               int'($urandom_range(63, 1)), int'($urandom_range(15, 0)),
               int'($urandom_range(15, 0)), int'($urandom_range(15, 0)), "random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule